// File: doc/BRIEF.md
# SPI Command and Fault Shift Interface

This block is the serial front end of a cell-balancing switch controller. A host talks to it over a four-wire SPI link in fixed one-byte frames. While the host shifts in a 4-bit command (MSB first, then four zero padding bits), the block shifts out the 4-bit fault code that the control core reported for the previous command. It then echoes the command it has just taken in, so the host can confirm what was received.

All SPI pins are brought into the core clock domain through two-flop synchronizers. Edges of the serial clock and chip select are detected there, so every register in the block runs on the single core clock. A frame that closes cleanly after exactly eight rising clock edges with all-zero padding hands the command to the control core as a one-cycle pulse. Frames that are cut short, padded with ones or over-clocked produce separate one-cycle fault pulses and never change the active command. The block also pulses an interrupt-clear strobe partway through each frame and a chip-select-fall strobe at the start of each frame.

Top module: `cmd_fault_spi`

## Requirements
- R1: A frame closed by chip select rising after exactly 8 rising SCLK edges with zero padding gives a one-cycle `cmd_valid` pulse. `cmd_data` then equals the first four MOSI bits (MSB first, sampled on SCLK rising edges) and holds that value until the next such pulse.
- R2: On chip select falling, `fault_code` is captured. Its bit 3 is presented on `spi_miso` before the first rising edge, and bits 2, 1 and 0 follow on SCLK falling edges 1 to 3.
- R3: After SCLK falling edges 4 to 7, `spi_miso` presents the command received in this frame, bit 3 first.
- R4: `spi_miso_oe` is high while chip select is low, after the synchronizer delay, and low a few core cycles after chip select rises.
- R5: When chip select rises after fewer than 8 rising edges, including none, `abort_pulse` is high for one cycle, no `cmd_valid` occurs and `cmd_data` is unchanged.
- R6: When a frame of exactly 8 rising edges has any padding bit (MOSI bits 5 to 8) sampled high, `pad_err` pulses for one cycle at close, no `cmd_valid` occurs and `cmd_data` is unchanged.
- R7: A 9th rising edge while chip select is low gives one `overrun_err` pulse during the frame. That frame then closes with no `cmd_valid`, `abort_pulse` or `pad_err`.
- R8: `irq_clear` pulses once per frame, on the 5th rising SCLK edge. This also happens in frames that are later aborted, and never in frames with 4 or fewer edges.
- R9: `cs_fall` pulses for exactly one cycle for each falling edge of chip select.
- R10: Synchronous reset clears `cmd_data` to 0, drops `spi_miso_oe` and all pulses, and restarts the bit counter, so a frame interrupted by reset leaves no abort and the next frame is decoded normally.
- R11: `cmd_valid`, `abort_pulse`, `pad_err` and `overrun_err` are each one cycle wide and never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, low when idle |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| fault_code | input | NIB_W | Fault code of the previous command from the control core |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| cmd_valid | output | 1 | One-cycle pulse: a new command was accepted |
| cmd_data | output | NIB_W | Last accepted command |
| irq_clear | output | 1 | One-cycle strobe to clear the fault interrupt |
| cs_fall | output | 1 | One-cycle strobe at each chip select falling edge |
| abort_pulse | output | 1 | One-cycle pulse: frame ended early |
| pad_err | output | 1 | One-cycle pulse: nonzero padding in a full frame |
| overrun_err | output | 1 | One-cycle pulse: 9th rising edge in a frame |

## Verification
The assertions assume that SCLK stays low while chip select is high, and that each SCLK and chip select level lasts well over three core cycles, so that the synchronizers see every edge. The bench keeps every serial phase at eight core cycles, drives SCLK only inside a selected frame, and returns it low before chip select rises. The stimulus includes frames with zero edges, four edges, five edges, eight edges and nine edges. It also includes padding errors at both the first and the last padding bit, and a reset arriving in the middle of a frame.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    // Bit positions of the SPI pins inside the synchronized bundle.
    localparam int IDX_CS   = 2;
    localparam int IDX_SCK  = 1;
    localparam int IDX_MOSI = 0;
    localparam int PIN_W    = 3;

    // Idle levels: chip select released, clock low, data low.
    localparam logic [PIN_W-1:0] PIN_IDLE = 3'b100;

    // Core-domain view of one sample of the serial link.
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
        logic cs_act;
        logic mosi;
    } spi_evt_t;

    // How a frame ended when chip select was released.
    typedef enum logic [1:0] {
        CLOSE_ABORT  = 2'd0,
        CLOSE_ACCEPT = 2'd1,
        CLOSE_PAD    = 2'd2,
        CLOSE_OVER   = 2'd3
    } close_e;

    function automatic spi_evt_t decode_evt(
        input logic [PIN_W-1:0] now,
        input logic [PIN_W-1:0] last
    );
        spi_evt_t e;
        e.cs_fall  = last[IDX_CS]  & ~now[IDX_CS];
        e.cs_rise  = ~last[IDX_CS] &  now[IDX_CS];
        e.sck_rise = ~last[IDX_SCK] &  now[IDX_SCK];
        e.sck_fall =  last[IDX_SCK] & ~now[IDX_SCK];
        e.cs_act   = ~now[IDX_CS];
        e.mosi     =  now[IDX_MOSI];
        return e;
    endfunction

    function automatic close_e classify(
        input int unsigned edges,
        input int unsigned frame_len,
        input logic        pad_hit
    );
        if (edges < frame_len) return CLOSE_ABORT;
        if (edges > frame_len) return CLOSE_OVER;
        if (pad_hit)           return CLOSE_PAD;
        return CLOSE_ACCEPT;
    endfunction

endpackage

// File: rtl/cfs_sync.sv
module cfs_sync #(
    parameter int                WIDTH  = 3,
    parameter int                STAGES = 2,
    parameter logic [WIDTH-1:0]  IDLE   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dlast
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain  <= {STAGES{IDLE[b]}};
                last_q <= IDLE[b];
            end else begin
                chain  <= {chain[STAGES-2:0], din[b]};
                last_q <= chain[STAGES-1];
            end
        end

        assign dout[b]  = chain[STAGES-1];
        assign dlast[b] = last_q;
    end

endmodule

// File: rtl/cfs_rx.sv
module cfs_rx
    import cfs_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  spi_evt_t         evt,
    output logic [NIB_W-1:0] cmd_shift,
    output logic             cmd_valid,
    output logic [NIB_W-1:0] cmd_data,
    output logic             abort_pulse,
    output logic             pad_err,
    output logic             overrun_err,
    output logic             irq_clear,
    output logic             cs_fall
);

    localparam int FRAME = 2 * NIB_W;
    localparam int CNT_W = $clog2(FRAME + 2);
    localparam logic [CNT_W-1:0] C_NIB   = CNT_W'(NIB_W);
    localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME);
    localparam logic [CNT_W-1:0] C_MAX   = CNT_W'(FRAME + 1);

    logic [CNT_W-1:0] edge_cnt;
    logic             pad_hit;
    logic             in_pad;
    close_e           outcome;

    assign in_pad  = (edge_cnt >= C_NIB) && (edge_cnt < C_FRAME);
    assign outcome = classify(32'(edge_cnt), 32'(FRAME), pad_hit);

    // Bit counter and command shifter.
    always_ff @(posedge clk) begin
        if (rst) begin
            edge_cnt  <= '0;
            cmd_shift <= '0;
            pad_hit   <= 1'b0;
        end else if (evt.cs_fall) begin
            edge_cnt  <= '0;
            pad_hit   <= 1'b0;
        end else if (evt.cs_act && evt.sck_rise) begin
            if (edge_cnt != C_MAX) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
            if (edge_cnt < C_NIB) begin
                cmd_shift <= {cmd_shift[NIB_W-2:0], evt.mosi};
            end
            if (in_pad && evt.mosi) begin
                pad_hit <= 1'b1;
            end
        end
    end

    // Mid-frame strobes.
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_clear   <= 1'b0;
            overrun_err <= 1'b0;
            cs_fall     <= 1'b0;
        end else begin
            cs_fall     <= evt.cs_fall;
            irq_clear   <= evt.cs_act && evt.sck_rise && (edge_cnt == C_NIB);
            overrun_err <= evt.cs_act && evt.sck_rise && (edge_cnt == C_FRAME);
        end
    end

    // Frame close.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid   <= 1'b0;
            abort_pulse <= 1'b0;
            pad_err     <= 1'b0;
            cmd_data    <= '0;
        end else begin
            cmd_valid   <= 1'b0;
            abort_pulse <= 1'b0;
            pad_err     <= 1'b0;
            if (evt.cs_rise) begin
                unique case (outcome)
                    CLOSE_ACCEPT: begin
                        cmd_valid <= 1'b1;
                        cmd_data  <= cmd_shift;
                    end
                    CLOSE_ABORT: abort_pulse <= 1'b1;
                    CLOSE_PAD:   pad_err     <= 1'b1;
                    CLOSE_OVER:  ;
                    default:     ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfs_tx.sv
module cfs_tx
    import cfs_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  spi_evt_t         evt,
    input  logic [NIB_W-1:0] fault_code,
    input  logic [NIB_W-1:0] cmd_shift,
    output logic             miso,
    output logic             miso_oe
);

    localparam int FRAME = 2 * NIB_W;
    localparam int CNT_W = $clog2(FRAME + 2);
    localparam logic [CNT_W-1:0] C_NIB = CNT_W'(NIB_W);
    localparam logic [CNT_W-1:0] C_MAX = CNT_W'(FRAME + 1);

    logic [NIB_W-1:0] out_sh;
    logic [CNT_W-1:0] fall_cnt;
    logic [CNT_W-1:0] fall_nxt;

    assign fall_nxt = (fall_cnt == C_MAX) ? fall_cnt : fall_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sh   <= '0;
            fall_cnt <= '0;
            miso_oe  <= 1'b0;
        end else begin
            miso_oe <= evt.cs_act;
            if (evt.cs_fall) begin
                out_sh   <= fault_code;
                fall_cnt <= '0;
            end else if (evt.cs_act && evt.sck_fall) begin
                fall_cnt <= fall_nxt;
                if (fall_nxt == C_NIB) begin
                    out_sh <= cmd_shift;
                end else begin
                    out_sh <= {out_sh[NIB_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = out_sh[NIB_W-1];

endmodule

// File: rtl/cmd_fault_spi.sv
module cmd_fault_spi
    import cfs_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    input  logic [NIB_W-1:0] fault_code,
    output logic             spi_miso,
    output logic             spi_miso_oe,
    output logic             cmd_valid,
    output logic [NIB_W-1:0] cmd_data,
    output logic             irq_clear,
    output logic             cs_fall,
    output logic             abort_pulse,
    output logic             pad_err,
    output logic             overrun_err
);

    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_now;
    logic [PIN_W-1:0] pins_last;
    logic [NIB_W-1:0] cmd_shift;
    spi_evt_t         evt;

    always_comb begin
        pins_raw           = '0;
        pins_raw[IDX_CS]   = spi_cs_n;
        pins_raw[IDX_SCK]  = spi_sclk;
        pins_raw[IDX_MOSI] = spi_mosi;
    end

    cfs_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .IDLE   (PIN_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (pins_raw),
        .dout  (pins_now),
        .dlast (pins_last)
    );

    assign evt = decode_evt(pins_now, pins_last);

    cfs_rx #(.NIB_W(NIB_W)) i_rx (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .cmd_shift   (cmd_shift),
        .cmd_valid   (cmd_valid),
        .cmd_data    (cmd_data),
        .abort_pulse (abort_pulse),
        .pad_err     (pad_err),
        .overrun_err (overrun_err),
        .irq_clear   (irq_clear),
        .cs_fall     (cs_fall)
    );

    cfs_tx #(.NIB_W(NIB_W)) i_tx (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .fault_code (fault_code),
        .cmd_shift  (cmd_shift),
        .miso       (spi_miso),
        .miso_oe    (spi_miso_oe)
    );

endmodule

// File: rtl/cmd_fault_spi_chk.sv
module cmd_fault_spi_chk #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             spi_cs_n,
    input logic             spi_miso_oe,
    input logic             cmd_valid,
    input logic [NIB_W-1:0] cmd_data,
    input logic             irq_clear,
    input logic             cs_fall,
    input logic             abort_pulse,
    input logic             pad_err,
    input logic             overrun_err
);

    AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R4

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> $stable(cmd_data)); // R1

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R11

    AST_CLOSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, abort_pulse, pad_err, overrun_err})); // R11

    AST_CLEAR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        irq_clear |-> (spi_miso_oe && !spi_cs_n)); // R8

    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_clear |=> !irq_clear); // R8

    AST_OVERRUN_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        overrun_err |-> spi_miso_oe); // R7

    AST_CSFALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> !cs_fall); // R9

endmodule

bind cmd_fault_spi cmd_fault_spi_chk #(.NIB_W(NIB_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .cmd_valid   (cmd_valid),
    .cmd_data    (cmd_data),
    .irq_clear   (irq_clear),
    .cs_fall     (cs_fall),
    .abort_pulse (abort_pulse),
    .pad_err     (pad_err),
    .overrun_err (overrun_err)
);

// File: tb/test_cmd_fault_spi.sv
module test_cmd_fault_spi;

    localparam int NIB_W = 4;
    localparam int HALF  = 8;
    localparam int NVEC  = 13;

    typedef struct packed {
        logic [3:0] nb;
        logic [7:0] dat;
        logic [3:0] flt;
        logic       v;
        logic       a;
        logic       p;
        logic       o;
        logic       c;
    } vec_t;

    // edges, byte sent, fault code, expect valid/abort/pad/overrun/clear
    localparam vec_t VEC [NVEC] = '{
        '{4'd8, 8'h30, 4'hA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'd8, 8'h70, 4'h5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'd8, 8'hF0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'd3, 8'hA0, 4'h6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd6, 8'h90, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{4'd8, 8'h58, 4'hC, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{4'd8, 8'h21, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{4'd9, 8'h40, 4'h9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{4'd0, 8'h00, 4'hE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd8, 8'h00, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'd4, 8'h50, 4'h2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd5, 8'h50, 4'hB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{4'd8, 8'hC0, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             spi_sclk = 1'b0;
    logic             spi_cs_n = 1'b1;
    logic             spi_mosi = 1'b0;
    logic [NIB_W-1:0] fault_code = '0;
    logic             spi_miso;
    logic             spi_miso_oe;
    logic             cmd_valid;
    logic [NIB_W-1:0] cmd_data;
    logic             irq_clear;
    logic             cs_fall;
    logic             abort_pulse;
    logic             pad_err;
    logic             overrun_err;

    always #2 clk = ~clk;

    cmd_fault_spi #(.NIB_W(NIB_W)) i_cmd_fault_spi (
        .clk         (clk),
        .rst         (rst),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .fault_code  (fault_code),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .cmd_valid   (cmd_valid),
        .cmd_data    (cmd_data),
        .irq_clear   (irq_clear),
        .cs_fall     (cs_fall),
        .abort_pulse (abort_pulse),
        .pad_err     (pad_err),
        .overrun_err (overrun_err)
    );

    int checks = 0;
    int fails  = 0;
    int n_valid = 0, n_abort = 0, n_pad = 0, n_ovr = 0, n_clr = 0, n_csf = 0;
    logic [3:0] exp_cmd = 4'h0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid)   n_valid++;
            if (abort_pulse) n_abort++;
            if (pad_err)     n_pad++;
            if (overrun_err) n_ovr++;
            if (irq_clear)   n_clr++;
            if (cs_fall)     n_csf++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input vec_t v);
        int b_valid, b_abort, b_pad, b_ovr, b_clr, b_csf;
        b_valid = n_valid; b_abort = n_abort; b_pad = n_pad;
        b_ovr = n_ovr; b_clr = n_clr; b_csf = n_csf;
        fault_code = v.flt;
        tick(1);
        spi_cs_n = 1'b0;
        tick(HALF);
        chk("R4 oe high in frame", int'(spi_miso_oe), 1);
        for (int i = 0; i < int'(v.nb); i++) begin
            spi_mosi = (i < 8) ? v.dat[7-i] : 1'b0;
            tick(HALF);
            if (i < 4)
                chk("R2 fault bit on miso", int'(spi_miso), int'(v.flt[3-i]));
            else if (i < 8)
                chk("R3 echo bit on miso", int'(spi_miso), int'(v.dat[11-i]));
            spi_sclk = 1'b1;
            tick(HALF);
            spi_sclk = 1'b0;
        end
        tick(HALF);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        tick(4 * HALF);
        chk("R4 oe low after frame", int'(spi_miso_oe), 0);
        chk("R1 valid pulses", n_valid - b_valid, int'(v.v));
        chk("R5 abort pulses", n_abort - b_abort, int'(v.a));
        chk("R6 pad error pulses", n_pad - b_pad, int'(v.p));
        chk("R7 overrun pulses", n_ovr - b_ovr, int'(v.o));
        chk("R8 irq clear pulses", n_clr - b_clr, int'(v.c));
        chk("R9 cs fall pulses", n_csf - b_csf, 1);
        if (v.v) exp_cmd = v.dat[7:4];
        chk("R1 cmd_data", int'(cmd_data), int'(exp_cmd));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(4);
        // R10 reset state
        chk("R10 oe after reset", int'(spi_miso_oe), 0);
        chk("R10 cmd_data after reset", int'(cmd_data), 0);
        chk("R10 no valid after reset", int'(cmd_valid), 0);
        chk("R10 no pulses after reset", n_abort + n_pad + n_ovr + n_clr + n_csf, 0);

        for (int k = 0; k < NVEC; k++) begin
            run_frame(VEC[k]);
        end

        // R10 reset in the middle of a frame
        begin
            int b_abort;
            int b_valid;
            fault_code = 4'h4;
            spi_cs_n = 1'b0;
            tick(HALF);
            for (int i = 0; i < 3; i++) begin
                spi_mosi = 1'b1;
                tick(HALF);
                spi_sclk = 1'b1;
                tick(HALF);
                spi_sclk = 1'b0;
            end
            rst = 1'b1;
            tick(3);
            spi_cs_n = 1'b1;
            spi_mosi = 1'b0;
            tick(HALF);
            b_abort = n_abort;
            b_valid = n_valid;
            rst = 1'b0;
            tick(4 * HALF);
            exp_cmd = 4'h0;
            chk("R10 cmd_data cleared by reset", int'(cmd_data), 0);
            chk("R10 no abort after reset", n_abort - b_abort, 0);
            chk("R10 no valid after reset", n_valid - b_valid, 0);
            chk("R10 oe low after reset", int'(spi_miso_oe), 0);
        end
        run_frame('{4'd8, 8'h60, 4'h8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule